// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block sits on the controller side of an asynchronous DRAM and decides when refresh work must happen. It counts system clock cycles from reset and keeps every access off the memory until the power-up pause has elapsed. It then asks for a fixed number of warm-up cycles that each contain a RAS pulse, and only after the last of these has been granted does it declare the memory ready. In normal operation a free-running interval timer adds one refresh to a small debt counter per interval, and the block asks an access arbiter for one CAS-before-RAS refresh for each unit of debt. When the debt grows past a threshold, the refresh request is flagged as urgent and normal accesses are held off until the debt drops again.

On command the block puts the memory into self refresh. It asks for one last refresh cycle, marked so that the pin sequencer keeps RAS low afterwards, and holds that mark until an exit command arrives. On exit it keeps RAS high for a precharge window. A build-time option then picks one of two variants. The burst variant requests a full sweep of every row before normal accesses resume. The distributed variant goes straight back to the periodic schedule.

The arbiter completes the handshake by pulsing the grant input for one cycle when a requested refresh cycle has finished. The RAS/CAS waveforms themselves are produced by a separate pin sequencer.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset release `ref_req`, `ready` and `self_ref` are low and `acc_block` is high. `ref_req` stays low for the first PAUSE_CYC clock cycles, and sr_enter/sr_exit pulses during that time have no effect.
- R2: Once the pause has elapsed, `ref_req` stays high until INIT_CYC grants have been received. `ready` rises in the cycle after the last of those grants and never falls again.
- R3: `acc_block` is high whenever `ready` is low.
- R4: In normal operation the debt grows by one every REF_INTERVAL_CYC cycles, counted from the first normal cycle, and each grant while the debt is nonzero lowers it by one. `ref_req` is high exactly when the debt is nonzero.
- R5: A grant pulse that arrives while the debt is zero in normal operation is ignored, so the debt does not wrap below zero.
- R6: The debt saturates at 2^DEBT_W-1. After any period without grants, exactly that many grants (plus interval ticks that fall during the drain) clear it.
- R7: `ref_urgent` is high exactly when the debt exceeds URGENT_TH, and `acc_block` is high while it is.
- R8: An `sr_enter` pulse in normal operation raises `self_ref` and `ref_req` in the next cycle. After the grant, `self_ref` stays high, `ref_req` falls, the debt is cleared and `acc_block` stays high.
- R9: An `sr_exit` pulse during self refresh drops `self_ref` in the next cycle. For PRECH_CYC cycles after that, `ref_req` stays low and `acc_block` stays high.
- R10: After the precharge window the burst variant (BURST_CATCHUP=1) requests ROWS grants with accesses blocked before it resumes normal operation. The distributed variant resumes normal operation at once, with the interval timer restarted.
- R11: `sr_exit` has no effect outside self refresh. `sr_enter` has no effect outside normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | One-cycle pulse: the requested refresh/warm-up cycle has completed |
| sr_enter | input | 1 | One-cycle command to enter self refresh |
| sr_exit | input | 1 | One-cycle command to leave self refresh |
| ref_req | output | 1 | Request for one RAS-bearing refresh cycle |
| ref_urgent | output | 1 | Refresh debt above threshold; refresh takes priority |
| self_ref | output | 1 | Tells the pin sequencer to keep RAS low after the granted cycle |
| ready | output | 1 | Initialization finished |
| acc_block | output | 1 | Normal accesses must be held off |

## Verification
Two instances run side by side, one per catch-up variant, and a behavioural model is compared with them on every clock. The grant stream is tried in several shapes. A stream that always grants shows the steady one-refresh-per-interval rhythm. A long starvation stretch drives the debt into saturation and the urgent flag. A stray grant with no debt outstanding shows whether the counter wraps. Commands are also issued in phases where they must be ignored. A full self-refresh entry and exit, applied to both instances at once, separates the two catch-up behaviours: one sweeps every row and the other resumes at once.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [2:0] {
      PH_PAUSE    = 3'd0,
      PH_WARMUP   = 3'd1,
      PH_RUN      = 3'd2,
      PH_SR_ENTRY = 3'd3,
      PH_SR_HOLD  = 3'd4,
      PH_SR_EXIT  = 3'd5,
      PH_CATCHUP  = 3'd6
   } rfsh_phase_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int unsigned INTERVAL = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = $clog2(INTERVAL + 1);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   // The count restarts from zero whenever normal operation is left.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run)            cnt_q <= '0;
      else if (cnt_q == LAST)   cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
   parameter int unsigned DEBT_W    = 4,
   parameter int unsigned URGENT_TH = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic gnt,
   input  logic clear,
   output logic nonzero,
   output logic urgent
);
   localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};
   localparam logic [DEBT_W-1:0] TH   = DEBT_W'(URGENT_TH);

   logic [DEBT_W-1:0] debt_q;
   logic              take;
   logic              add;

   assign take = enable && gnt && (debt_q != '0);
   assign add  = enable && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              debt_q <= '0;
      else if (clear)                          debt_q <= '0;
      else if (add && !take && debt_q != DMAX) debt_q <= debt_q + 1'b1;
      else if (take && !add)                   debt_q <= debt_q - 1'b1;
   end

   assign nonzero = (debt_q != '0);
   assign urgent  = (debt_q > TH);
endmodule

// File: rtl/rfsh_phase_fsm.sv
module rfsh_phase_fsm
   import rfsh_pkg::*;
#(
   parameter int unsigned PAUSE_CYC     = 25000,
   parameter int unsigned INIT_CYC      = 8,
   parameter int unsigned PRECH_CYC     = 12,
   parameter int unsigned ROWS          = 1024,
   parameter bit          BURST_CATCHUP = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        gnt,
   input  logic        sr_enter,
   input  logic        sr_exit,
   output rfsh_phase_e phase
);
   localparam int unsigned SPAN = max4(PAUSE_CYC, INIT_CYC, PRECH_CYC, ROWS);
   localparam int unsigned SW   = $clog2(SPAN + 1);
   localparam logic [SW-1:0] PAUSE_LAST = SW'(PAUSE_CYC - 1);
   localparam logic [SW-1:0] INIT_LAST  = SW'(INIT_CYC - 1);
   localparam logic [SW-1:0] PRECH_LAST = SW'(PRECH_CYC - 1);
   localparam logic [SW-1:0] ROWS_LAST  = SW'(ROWS - 1);

   rfsh_phase_e phase_q, phase_d;
   logic [SW-1:0] step_q, step_d;
   rfsh_phase_e after_exit;

   generate
      if (BURST_CATCHUP) begin : g_burst
         assign after_exit = PH_CATCHUP;
      end else begin : g_distributed
         assign after_exit = PH_RUN;
      end
   endgenerate

   always_comb begin
      phase_d = phase_q;
      step_d  = step_q;
      unique case (phase_q)
         PH_PAUSE: begin
            if (step_q == PAUSE_LAST) begin
               phase_d = PH_WARMUP;
               step_d  = '0;
            end else begin
               step_d = step_q + 1'b1;
            end
         end
         PH_WARMUP: begin
            if (gnt) begin
               if (step_q == INIT_LAST) begin
                  phase_d = PH_RUN;
                  step_d  = '0;
               end else begin
                  step_d = step_q + 1'b1;
               end
            end
         end
         PH_RUN: begin
            if (sr_enter) phase_d = PH_SR_ENTRY;
         end
         PH_SR_ENTRY: begin
            if (gnt) phase_d = PH_SR_HOLD;
         end
         PH_SR_HOLD: begin
            if (sr_exit) begin
               phase_d = PH_SR_EXIT;
               step_d  = '0;
            end
         end
         PH_SR_EXIT: begin
            if (step_q == PRECH_LAST) begin
               phase_d = after_exit;
               step_d  = '0;
            end else begin
               step_d = step_q + 1'b1;
            end
         end
         PH_CATCHUP: begin
            if (gnt) begin
               if (step_q == ROWS_LAST) begin
                  phase_d = PH_RUN;
                  step_d  = '0;
               end else begin
                  step_d = step_q + 1'b1;
               end
            end
         end
         default: begin
            phase_d = PH_PAUSE;
            step_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PAUSE;
         step_q  <= '0;
      end else begin
         phase_q <= phase_d;
         step_q  <= step_d;
      end
   end

   assign phase = phase_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int unsigned PAUSE_CYC        = 25000,
   parameter int unsigned INIT_CYC         = 8,
   parameter int unsigned REF_INTERVAL_CYC = 1950,
   parameter int unsigned PRECH_CYC        = 12,
   parameter int unsigned ROWS             = 1024,
   parameter int unsigned DEBT_W           = 4,
   parameter int unsigned URGENT_TH        = 6,
   parameter bit          BURST_CATCHUP    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   input  logic sr_enter,
   input  logic sr_exit,
   output logic ref_req,
   output logic ref_urgent,
   output logic self_ref,
   output logic ready,
   output logic acc_block
);
   generate
      if (PAUSE_CYC < 1 || INIT_CYC < 1 || PRECH_CYC < 1 || ROWS < 1) begin : g_bad_counts
         $error("dram_refresh_sched: cycle counts must be at least one");
      end
      if (REF_INTERVAL_CYC < 2) begin : g_bad_interval
         $error("dram_refresh_sched: refresh interval must be at least two cycles");
      end
      if (DEBT_W < 2 || URGENT_TH >= (1 << DEBT_W) - 1) begin : g_bad_debt
         $error("dram_refresh_sched: urgent threshold must lie below the debt ceiling");
      end
   endgenerate

   rfsh_phase_e phase;
   logic        in_run;
   logic        tick;
   logic        debt_nz;
   logic        debt_urgent;
   logic        debt_clear;

   rfsh_phase_fsm #(
      .PAUSE_CYC     (PAUSE_CYC),
      .INIT_CYC      (INIT_CYC),
      .PRECH_CYC     (PRECH_CYC),
      .ROWS          (ROWS),
      .BURST_CATCHUP (BURST_CATCHUP)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt      (ref_gnt),
      .sr_enter (sr_enter),
      .sr_exit  (sr_exit),
      .phase    (phase)
   );

   assign in_run     = (phase == PH_RUN);
   assign debt_clear = (phase == PH_SR_ENTRY) && ref_gnt;

   rfsh_interval_timer #(
      .INTERVAL (REF_INTERVAL_CYC)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_run),
      .tick  (tick)
   );

   rfsh_debt #(
      .DEBT_W    (DEBT_W),
      .URGENT_TH (URGENT_TH)
   ) u_debt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (in_run),
      .tick    (tick),
      .gnt     (ref_gnt),
      .clear   (debt_clear),
      .nonzero (debt_nz),
      .urgent  (debt_urgent)
   );

   assign ready      = (phase != PH_PAUSE) && (phase != PH_WARMUP);
   assign self_ref   = (phase == PH_SR_ENTRY) || (phase == PH_SR_HOLD);
   assign ref_urgent = debt_urgent;
   assign ref_req    = (phase == PH_WARMUP) || (phase == PH_SR_ENTRY) ||
                       (phase == PH_CATCHUP) || (in_run && debt_nz);
   assign acc_block  = !ready || debt_urgent || !in_run;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
   parameter int unsigned PAUSE_CYC = 25000
) (
   input logic clk,
   input logic rst_n,
   input logic ref_gnt,
   input logic sr_enter,
   input logic sr_exit,
   input logic ref_req,
   input logic ref_urgent,
   input logic self_ref,
   input logic ready,
   input logic acc_block
);
   logic [31:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      since_rst <= '0;
      else if (since_rst < PAUSE_CYC)  since_rst <= since_rst + 1;
   end

   assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < PAUSE_CYC) |-> (!ref_req && !ready));

   assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   assert_block_until_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> acc_block);

   assert_urgent_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> (ref_req && acc_block));

   assert_urgent_falls_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_urgent) |-> $past(ref_gnt));

   assert_selfref_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      self_ref |-> (ready && acc_block));

   assert_exit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(self_ref) |-> (!ref_req && acc_block));

   assert_stray_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_exit && !sr_enter && !self_ref) |=> !self_ref);
endmodule

bind dram_refresh_sched rfsh_sched_chk #(.PAUSE_CYC(PAUSE_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_gnt    (ref_gnt),
   .sr_enter   (sr_enter),
   .sr_exit    (sr_exit),
   .ref_req    (ref_req),
   .ref_urgent (ref_urgent),
   .self_ref   (self_ref),
   .ready      (ready),
   .acc_block  (acc_block)
);

// File: tb/rfsh_ref_model.sv
module rfsh_ref_model #(
   parameter int PAUSE  = 40,
   parameter int INIT   = 8,
   parameter int INTV   = 20,
   parameter int PRECH  = 6,
   parameter int NROWS  = 16,
   parameter int DMAX   = 7,
   parameter int TH     = 3,
   parameter bit BURST  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gnt,
   input  logic sr_enter,
   input  logic sr_exit,
   output logic e_req,
   output logic e_urg,
   output logic e_sref,
   output logic e_rdy,
   output logic e_blk
);
   // 0 pause, 1 warm-up, 2 normal, 3 entering, 4 holding, 5 leaving, 6 sweep
   int ph, n, t, debt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= 0; n <= 0; t <= 0; debt <= 0;
      end else begin
         if (ph == 2) begin
            int d;
            d = debt;
            if (t == INTV - 1) d = d + 1;
            if (gnt && debt > 0) d = d - 1;
            if (d > DMAX) d = DMAX;
            debt <= d;
            t <= (t == INTV - 1) ? 0 : t + 1;
            if (sr_enter) ph <= 3;
         end else begin
            t <= 0;
            case (ph)
               0: begin n <= n + 1; if (n + 1 == PAUSE) begin ph <= 1; n <= 0; end end
               1: if (gnt) begin n <= n + 1; if (n + 1 == INIT) begin ph <= 2; n <= 0; end end
               3: if (gnt) begin ph <= 4; debt <= 0; end
               4: if (sr_exit) begin ph <= 5; n <= 0; end
               5: begin n <= n + 1; if (n + 1 == PRECH) begin ph <= BURST ? 6 : 2; n <= 0; end end
               6: if (gnt) begin n <= n + 1; if (n + 1 == NROWS) begin ph <= 2; n <= 0; end end
               default: ph <= 0;
            endcase
         end
      end
   end

   assign e_req  = (ph == 1) || (ph == 3) || (ph == 6) || (ph == 2 && debt > 0);
   assign e_urg  = debt > TH;
   assign e_sref = (ph == 3) || (ph == 4);
   assign e_rdy  = ph >= 2;
   assign e_blk  = !e_rdy || e_urg || ph != 2;
endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
   localparam int PAUSE = 40, INIT = 8, INTV = 20, PRECH = 6, NROWS = 16, DW = 3, TH = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sr_enter = 1'b0, sr_exit = 1'b0;
   logic gnt_en = 1'b0, gnt_force = 1'b0;
   logic gnt_b = 1'b0, gnt_d = 1'b0;
   logic req_b, urg_b, sref_b, rdy_b, blk_b;
   logic req_d, urg_d, sref_d, rdy_d, blk_d;
   logic mreq_b, murg_b, msref_b, mrdy_b, mblk_b;
   logic mreq_d, murg_d, msref_d, mrdy_d, mblk_d;
   int   vectors = 0, miscompares = 0, cyc = 0;
   bit   done = 1'b0;
   string tag = "R1";

   always #4 clk = ~clk;

   dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REF_INTERVAL_CYC(INTV),
      .PRECH_CYC(PRECH), .ROWS(NROWS), .DEBT_W(DW), .URGENT_TH(TH), .BURST_CATCHUP(1'b1))
   u_dram_refresh_sched (.clk(clk), .rst_n(rst_n), .ref_gnt(gnt_b), .sr_enter(sr_enter),
      .sr_exit(sr_exit), .ref_req(req_b), .ref_urgent(urg_b), .self_ref(sref_b),
      .ready(rdy_b), .acc_block(blk_b));

   dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REF_INTERVAL_CYC(INTV),
      .PRECH_CYC(PRECH), .ROWS(NROWS), .DEBT_W(DW), .URGENT_TH(TH), .BURST_CATCHUP(1'b0))
   u_dram_refresh_sched_dist (.clk(clk), .rst_n(rst_n), .ref_gnt(gnt_d), .sr_enter(sr_enter),
      .sr_exit(sr_exit), .ref_req(req_d), .ref_urgent(urg_d), .self_ref(sref_d),
      .ready(rdy_d), .acc_block(blk_d));

   rfsh_ref_model #(.PAUSE(PAUSE), .INIT(INIT), .INTV(INTV), .PRECH(PRECH), .NROWS(NROWS),
      .DMAX((1 << DW) - 1), .TH(TH), .BURST(1'b1))
   m_burst (.clk(clk), .rst_n(rst_n), .gnt(gnt_b), .sr_enter(sr_enter), .sr_exit(sr_exit),
      .e_req(mreq_b), .e_urg(murg_b), .e_sref(msref_b), .e_rdy(mrdy_b), .e_blk(mblk_b));

   rfsh_ref_model #(.PAUSE(PAUSE), .INIT(INIT), .INTV(INTV), .PRECH(PRECH), .NROWS(NROWS),
      .DMAX((1 << DW) - 1), .TH(TH), .BURST(1'b0))
   m_dist (.clk(clk), .rst_n(rst_n), .gnt(gnt_d), .sr_enter(sr_enter), .sr_exit(sr_exit),
      .e_req(mreq_d), .e_urg(murg_d), .e_sref(msref_d), .e_rdy(mrdy_d), .e_blk(mblk_d));

   task automatic check(input string req, input string what, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s at cycle %0d: got %b expected %b", req, what, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // Simple arbiter: grant whatever is requested when enabled.
   always @(negedge clk) begin
      gnt_b <= (gnt_en && req_b) || gnt_force;
      gnt_d <= (gnt_en && req_d) || gnt_force;
   end

   // Every-cycle comparison against the reference model, tagged by the phase under test.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "burst ref_req",    req_b,  mreq_b);
         check(tag, "burst ref_urgent", urg_b,  murg_b);
         check(tag, "burst self_ref",   sref_b, msref_b);
         check(tag, "burst ready",      rdy_b,  mrdy_b);
         check(tag, "burst acc_block",  blk_b,  mblk_b);
         check(tag, "dist ref_req",     req_d,  mreq_d);
         check(tag, "dist ref_urgent",  urg_d,  murg_d);
         check(tag, "dist self_ref",    sref_d, msref_d);
         check(tag, "dist ready",       rdy_d,  mrdy_d);
         check(tag, "dist acc_block",   blk_d,  mblk_d);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !done) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete (got hang, expected finish)");
         finish_run();
      end
   end

   task automatic wait_cycles(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic pulse_enter();
      sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
   endtask

   task automatic pulse_exit();
      sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
   endtask

   initial begin
      wait_cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "ref_req after reset",   req_b, 1'b0);
      check("R1", "ready after reset",     rdy_b, 1'b0);
      check("R1", "self_ref after reset",  sref_b, 1'b0);
      check("R1", "acc_block after reset", blk_d, 1'b1);
      // R11: commands during the pause are ignored
      tag = "R11";
      wait_cycles(5);
      pulse_enter();
      wait_cycles(2);
      pulse_exit();
      check("R11", "self_ref after stray cmds", sref_b, 1'b0);
      wait_cycles(PAUSE);
      // R2: warm-up requests pending, no grant yet
      tag = "R2";
      check("R2", "warm-up ref_req", req_b, 1'b1);
      check("R3", "acc_block before ready", blk_b, 1'b1);
      wait_cycles(10);
      gnt_en = 1'b1;
      wait_cycles(INIT + 6);
      check("R2", "ready after warm-up", rdy_b, 1'b1);
      check("R2", "ready after warm-up dist", rdy_d, 1'b1);
      // R4: steady refresh with an always-granting arbiter
      tag = "R4";
      wait_cycles(5 * INTV);
      check("R4", "acc_block in steady run", blk_b, 1'b0);
      // R5: stray grant with no debt
      tag = "R5";
      gnt_force = 1'b1; @(negedge clk); gnt_force = 1'b0;
      wait_cycles(INTV + 3);
      // R6/R7: starvation to saturation
      tag = "R6";
      gnt_en = 1'b0;
      wait_cycles(14 * INTV);
      check("R7", "urgent after starvation", urg_b, 1'b1);
      check("R7", "acc_block while urgent", blk_b, 1'b1);
      gnt_en = 1'b1;
      wait_cycles(12);
      check("R6", "debt drained after saturation", urg_b, 1'b0);
      wait_cycles(INTV);
      // R11: exit command during normal operation
      tag = "R11";
      pulse_exit();
      wait_cycles(3);
      check("R11", "self_ref after stray exit", sref_b, 1'b0);
      // R8: enter self refresh
      tag = "R8";
      pulse_enter();
      wait_cycles(40);
      check("R8", "self_ref held", sref_b, 1'b1);
      check("R8", "no request while held", req_b, 1'b0);
      check("R8", "accesses blocked while held", blk_d, 1'b1);
      // R9: exit and precharge
      tag = "R9";
      pulse_exit();
      wait_cycles(2);
      check("R9", "self_ref dropped", sref_b, 1'b0);
      check("R9", "quiet during precharge", req_b, 1'b0);
      check("R9", "blocked during precharge", blk_b, 1'b1);
      // R10: catch-up variants
      tag = "R10";
      wait_cycles(PRECH);
      check("R10", "burst sweep blocks", blk_b, 1'b1);
      check("R10", "distributed resumes", blk_d, 1'b0);
      wait_cycles(NROWS + 20);
      check("R10", "burst resumed", blk_b, 1'b0);
      wait_cycles(3 * INTV);
      finish_run();
   end
endmodule